// File: doc/BRIEF.md
# Memory Exercise Sequencer

This block drives an external memory controller through a small request/response port so that a board can show the memory working with nothing but buttons, switches and LEDs. Once the controller signals that its start-up is done, the sequencer writes sixteen 64-bit words with a known pattern and then reads word 0 back. The returned word is held in a display register, and a status LED comes on.

After that the block waits for single-cycle button pulses. Two of them move a row pointer, one writes a fixed 64-bit word at the current row, and one reads the current row into the display register. A 3-bit selector picks which byte of the displayed word appears on the eight LEDs.

Every access moves one 64-bit word as a burst of four 16-bit beats. The memory address is packed with the row in the top bits, the column in the middle and the bank in the lowest bits.

Top module: `memseq_top`

## Requirements
- R1: After reset, no request is issued until `init_done` has been seen high. While the block is waiting for that signal, `req_valid` stays low.
- R2: The start-up fill issues exactly 16 writes. Write k (k = 0..15) goes to row 0, bank 0, column 4k. Its data is 0123456789ABCDEF rotated left by 4k bits for k = 0..5, and 639CC6398C7318E7 for k = 6..15.
- R3: After the 16th write is accepted, one read of address 0 is issued. When its data returns, the display register takes it and `led_ready` goes high. `led_ready` then stays high until reset.
- R4: `req_addr` is {row[12:0], col[9:0], bank[1:0]}, with the row in the most significant bits. Bits 3:0 of every request are zero. Interactive accesses use column 0 and bank 0.
- R5: When idle, a pulse on `btn_up` adds one to the row pointer and a pulse on `btn_down` subtracts one. Both wrap modulo 8192. The row pointer resets to 0.
- R6: When idle, a pulse on `btn_store` issues one write of 31CE629DC43B8877 to the current row.
- R7: When idle, a pulse on `btn_fetch` issues one read of the current row. The display register takes `rsp_data` in the first cycle after acceptance in which `rsp_valid` is high. The display register resets to 0 and changes only on a completed read.
- R8: A request whose `req_valid` is high and `req_ready` is low keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` unchanged in the next cycle.
- R9: `led` equals bits [8n+7:8n] of the display register, where n is the value on `byte_sel`.
- R10: Button pulses are ignored before `led_ready` is high and while an access is outstanding. If several pulses arrive in the same idle cycle, only the highest-priority one acts, in the order up, down, store, fetch.
- R11: An active-high `rst` returns the block to waiting for `init_done`, clears `led_ready` and clears the display register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Memory controller start-up complete |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Controller accepts the request this cycle |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 25 | Packed {row, column, bank} address |
| req_wdata | output | 64 | Write data |
| rsp_valid | input | 1 | Read data present |
| rsp_data | input | 64 | Read data |
| btn_up | input | 1 | One-cycle pulse: row pointer up |
| btn_down | input | 1 | One-cycle pulse: row pointer down |
| btn_store | input | 1 | One-cycle pulse: write the fixed word |
| btn_fetch | input | 1 | One-cycle pulse: read the current row |
| byte_sel | input | 3 | Byte select for the LEDs |
| led | output | 8 | Selected byte of the displayed word |
| led_ready | output | 1 | Start-up fill and readback completed |

## Verification
A button pulse sampled at one clock edge raises `req_valid` from that same edge. A request is handed over at the first edge where `req_ready` is also high. A read's data is registered at the edge that samples `rsp_valid`, so it is visible on `led` one cycle after the model drives the response. `led` follows `byte_sel` within the same cycle.

The bench drives every input and samples every output shortly after the falling edge. It waits for the memory model's own counters of accepted writes, accepted reads and delivered responses, and checks one cycle after the response edge. It never counts cycles across the random `req_ready` stalls.

Pulses meant to be ignored are placed in the cycle right after a store or fetch pulse, when the access is certainly still outstanding. The address of the next access then shows whether the row pointer moved.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

    typedef enum logic [2:0] {
        ST_INIT_WAIT,
        ST_FILL,
        ST_VERIFY_REQ,
        ST_VERIFY_WAIT,
        ST_IDLE,
        ST_STORE,
        ST_FETCH_REQ,
        ST_FETCH_WAIT
    } seq_state_e;

    localparam logic [63:0] FILL_SEED  = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] FILL_TAIL  = 64'h639C_C639_8C73_18E7;
    localparam logic [63:0] STORE_WORD = 64'h31CE_629D_C43B_8877;

endpackage

// File: rtl/memseq_pattern.sv
module memseq_pattern #(
    parameter int          DATA_W    = 64,
    parameter int          IDX_W     = 4,
    parameter int          ROT_WORDS = 6,
    parameter logic [63:0] SEED      = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] TAIL      = 64'h639C_C639_8C73_18E7
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    localparam int SH_W = $clog2(DATA_W) + 1;

    logic [SH_W-1:0] shift;

    always_comb begin
        shift = SH_W'(idx) << 2;
        if (32'(idx) < ROT_WORDS) begin
            word = (SEED[DATA_W-1:0] << shift) | (SEED[DATA_W-1:0] >> (SH_W'(DATA_W) - shift));
            if (idx == '0) begin
                word = SEED[DATA_W-1:0];
            end
        end else begin
            word = TAIL[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/memseq_addr.sv
module memseq_addr #(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BANK_W = 2
) (
    input  logic [ROW_W-1:0]              row,
    input  logic [COL_W-1:0]              col,
    input  logic [BANK_W-1:0]             bank,
    output logic [ROW_W+COL_W+BANK_W-1:0] addr
);
    assign addr = {row, col, bank};
endmodule

// File: rtl/memseq_bytesel.sv
module memseq_bytesel #(
    parameter int DATA_W = 64,
    parameter int SEL_W  = 3
) (
    input  logic [DATA_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [7:0]        out
);
    localparam int LANES = DATA_W / 8;

    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[8*g +: 8];
    end

    always_comb begin
        out = '0;
        for (int i = 0; i < LANES; i++) begin
            if (32'(sel) == i) begin
                out = lane[i];
            end
        end
    end
endmodule

// File: rtl/memseq_top.sv
module memseq_top #(
    parameter int ROW_W      = 13,
    parameter int COL_W      = 10,
    parameter int BANK_W     = 2,
    parameter int DATA_W     = 64,
    parameter int BURST      = 4,
    parameter int FILL_WORDS = 16,
    parameter int ROT_WORDS  = 6,
    parameter int SEL_W      = 3,
    parameter int ADDR_W     = ROW_W + COL_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_done,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              btn_up,
    input  logic              btn_down,
    input  logic              btn_store,
    input  logic              btn_fetch,
    input  logic [SEL_W-1:0]  byte_sel,
    output logic [7:0]        led,
    output logic              led_ready
);
    import memseq_pkg::*;

    localparam int IDX_W     = $clog2(FILL_WORDS);
    localparam int BURST_SH  = $clog2(BURST);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FILL_WORDS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [IDX_W-1:0]  fill_idx;
        logic [ROW_W-1:0]  row;
        logic [DATA_W-1:0] shown;
        logic              done;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              hs;
    logic [DATA_W-1:0] fill_word;
    logic [ROW_W-1:0]  sel_row;
    logic [COL_W-1:0]  sel_col;

    memseq_pattern #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .ROT_WORDS(ROT_WORDS),
        .SEED(FILL_SEED), .TAIL(FILL_TAIL)
    ) u_pat (
        .idx (q.fill_idx),
        .word(fill_word)
    );

    memseq_addr #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_addr (
        .row (sel_row),
        .col (sel_col),
        .bank('0),
        .addr(req_addr)
    );

    memseq_bytesel #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bsel (
        .word(q.shown),
        .sel (byte_sel),
        .out (led)
    );

    // Request outputs decoded from the registered state only
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_wdata = '0;
        sel_row   = '0;
        sel_col   = '0;
        unique case (q.state)
            ST_FILL: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = fill_word;
                sel_col   = COL_W'(q.fill_idx) << BURST_SH;
            end
            ST_VERIFY_REQ: begin
                req_valid = 1'b1;
            end
            ST_STORE: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = STORE_WORD[DATA_W-1:0];
                sel_row   = q.row;
            end
            ST_FETCH_REQ: begin
                req_valid = 1'b1;
                sel_row   = q.row;
            end
            default: begin
                sel_row = q.row;
            end
        endcase
    end

    assign hs        = req_valid && req_ready;
    assign led_ready = q.done;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_INIT_WAIT: begin
                if (init_done) begin
                    d.state    = ST_FILL;
                    d.fill_idx = '0;
                end
            end
            ST_FILL: begin
                if (hs) begin
                    if (q.fill_idx == LAST_IDX) begin
                        d.state = ST_VERIFY_REQ;
                    end else begin
                        d.fill_idx = q.fill_idx + 1'b1;
                    end
                end
            end
            ST_VERIFY_REQ: begin
                if (hs) d.state = ST_VERIFY_WAIT;
            end
            ST_VERIFY_WAIT: begin
                if (rsp_valid) begin
                    d.shown = rsp_data;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (btn_up) begin
                    d.row = q.row + 1'b1;
                end else if (btn_down) begin
                    d.row = q.row - 1'b1;
                end else if (btn_store) begin
                    d.state = ST_STORE;
                end else if (btn_fetch) begin
                    d.state = ST_FETCH_REQ;
                end
            end
            ST_STORE: begin
                if (hs) d.state = ST_IDLE;
            end
            ST_FETCH_REQ: begin
                if (hs) d.state = ST_FETCH_WAIT;
            end
            ST_FETCH_WAIT: begin
                if (rsp_valid) begin
                    d.shown = rsp_data;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_INIT_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state    <= ST_INIT_WAIT;
            q.fill_idx <= '0;
            q.row      <= '0;
            q.shown    <= '0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/memseq_checker.sv
module memseq_checker #(
    parameter int ADDR_W = 25,
    parameter int DATA_W = 64,
    parameter int BANK_W = 2,
    parameter int BURST  = 4,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              init_done,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [SEL_W-1:0]  byte_sel,
    input logic [7:0]        led,
    input logic              led_ready
);
    localparam int LOWB = BANK_W + $clog2(BURST);

    a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_write)
            && $stable(req_addr) && $stable(req_wdata)));

    a_r4_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[LOWB-1:0] == '0));

    a_r3_status_sticky: assert property (@(posedge clk) disable iff (rst)
        led_ready |=> led_ready);

    a_r1_quiet_before_init: assert property (@(posedge clk) disable iff (rst)
        (!init_done && !req_valid && !led_ready) |=> !req_valid);

    a_r7_display_hold: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> ($stable(led) || !$stable(byte_sel)));
endmodule

bind memseq_top memseq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .BURST(BURST), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst(rst), .init_done(init_done), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .byte_sel(byte_sel),
    .led(led), .led_ready(led_ready)
);

// File: tb/sim_memseq_top.sv
module sim_memseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_done = 1'b0;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [24:0] req_addr;
    logic [63:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic [3:0]  btn = '0;
    logic [2:0]  byte_sel = '0;
    logic [7:0]  led;
    logic        led_ready;

    always #5 clk = ~clk;

    memseq_top u0 (
        .clk(clk), .rst(rst), .init_done(init_done),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .btn_up(btn[0]), .btn_down(btn[1]), .btn_store(btn[2]), .btn_fetch(btn[3]),
        .byte_sel(byte_sel), .led(led), .led_ready(led_ready)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // Memory model state
    logic [63:0] mem [logic [24:0]];
    int          wr_cnt = 0, rd_cnt = 0, rsp_cnt = 0;
    logic [24:0] last_wr_addr, last_rd_addr, pend_addr;
    logic [63:0] last_wr_data, last_rsp;
    bit          pend = 0;
    int          pend_cnt = 0;
    bit          spurious_en = 0;

    function automatic logic [63:0] mem_read(logic [24:0] a);
        if (mem.exists(a)) return mem[a];
        return {39'd0, a} ^ 64'h5A5A_0000_0000_0000;
    endfunction

    function automatic logic [63:0] exp_fill(int k);
        logic [63:0] w = 64'h0123_4567_89AB_CDEF;
        if (k >= 6) return 64'h639C_C639_8C73_18E7;
        for (int i = 0; i < k; i++) w = {w[59:0], w[63:60]};
        return w;
    endfunction

    function automatic logic [24:0] exp_addr(logic [12:0] row, logic [9:0] col);
        return {row, col, 2'b00};
    endfunction

    function automatic logic [7:0] exp_byte(logic [63:0] w, logic [2:0] s);
        return w[8*s +: 8];
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            req_ready = 1'b0;
            rsp_valid = 1'b0;
            pend = 0;
        end else begin
            rsp_valid = 1'b0;
            if (pend) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mem_read(pend_addr);
                    last_rsp  = rsp_data;
                    pend      = 0;
                    rsp_cnt++;
                end
            end else if (spurious_en && ($urandom % 8 == 0)) begin
                rsp_valid = 1'b1;
                rsp_data  = {$urandom, $urandom};
            end
            req_ready = ($urandom % 4) != 0;
            if (req_valid && req_ready) begin
                if (req_write) begin
                    mem[req_addr] = req_wdata;
                    last_wr_addr  = req_addr;
                    last_wr_data  = req_wdata;
                    wr_cnt++;
                end else begin
                    last_rd_addr = req_addr;
                    pend_addr    = req_addr;
                    pend         = 1;
                    pend_cnt     = 1 + int'($urandom % 4);
                    rd_cnt++;
                end
            end
        end
    end

    task automatic pulse(logic [3:0] b);
        @(negedge clk); #1;
        btn = b;
        @(negedge clk); #1;
        btn = '0;
    endtask

    // second pulse lands in the cycle after the first, while the access is outstanding
    task automatic pulse_pair(logic [3:0] a, logic [3:0] b);
        @(negedge clk); #1;
        btn = a;
        @(negedge clk); #1;
        btn = b;
        @(negedge clk); #1;
        btn = '0;
    endtask

    task automatic wait_wr(int old);
        while (wr_cnt == old) begin @(negedge clk); #1; end
    endtask

    task automatic wait_rsp(int old);
        while (rsp_cnt == old) begin @(negedge clk); #1; end
        @(negedge clk); #1;
    endtask

    task automatic do_store(logic [12:0] row, bit extra);
        int old = wr_cnt;
        if (extra) pulse_pair(4'b0100, 4'b0001);
        else pulse(4'b0100);
        wait_wr(old);
        check(last_wr_addr == exp_addr(row, 10'd0), "R6 store address",
              64'(last_wr_addr), 64'(exp_addr(row, 10'd0)));
        check(last_wr_data == 64'h31CE_629D_C43B_8877, "R6 store data",
              last_wr_data, 64'h31CE_629D_C43B_8877);
    endtask

    task automatic do_fetch(logic [12:0] row, bit extra);
        int old = rsp_cnt;
        logic [2:0] s = 3'($urandom);
        if (extra) pulse_pair(4'b1000, 4'b0010);
        else pulse(4'b1000);
        wait_rsp(old);
        check(last_rd_addr == exp_addr(row, 10'd0), "R7 fetch address",
              64'(last_rd_addr), 64'(exp_addr(row, 10'd0)));
        byte_sel = s; #1;
        check(led == exp_byte(last_rsp, s), "R7 R9 displayed byte",
              64'(led), 64'(exp_byte(last_rsp, s)));
    endtask

    task automatic startup_and_check(bit early_pulse);
        int wbase = wr_cnt;
        int rbase = rsp_cnt;
        init_done = 1'b1;
        if (early_pulse) pulse(4'b0001);   // R10: ignored before done
        while (wr_cnt < wbase + 16) begin @(negedge clk); #1; end
        check(led_ready == 1'b0, "R3 status low before readback", 64'(led_ready), 64'd0);
        while (!led_ready) begin @(negedge clk); #1; end
        check(wr_cnt == wbase + 16, "R2 fill write count", 64'(wr_cnt - wbase), 64'd16);
        for (int k = 0; k < 16; k++) begin
            logic [24:0] a = exp_addr(13'd0, 10'(4 * k));
            check(mem.exists(a) && mem[a] == exp_fill(k), "R2 fill word",
                  mem_read(a), exp_fill(k));
        end
        check(last_rd_addr == 25'd0 && rsp_cnt == rbase + 1, "R3 readback of word 0",
              64'(last_rd_addr), 64'd0);
        for (int s = 0; s < 8; s++) begin
            byte_sel = 3'(s); #1;
            check(led == exp_byte(exp_fill(0), 3'(s)), "R9 byte select after readback",
                  64'(led), 64'(exp_byte(exp_fill(0), 3'(s))));
        end
    endtask

    initial begin
        logic [12:0] row;
        int          oldw, oldr;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        #1;
        check(req_valid == 1'b0, "R11 reset request idle", 64'(req_valid), 64'd0);
        check(led_ready == 1'b0, "R11 reset status", 64'(led_ready), 64'd0);
        check(led == 8'd0, "R7 display reset to zero", 64'(led), 64'd0);
        rst = 1'b0;
        repeat (8) begin
            @(negedge clk); #1;
            check(req_valid == 1'b0, "R1 no request before init", 64'(req_valid), 64'd0);
        end

        startup_and_check(1'b1);
        row = 13'd0;
        do_store(row, 1'b0);                 // R10: early up pulse had no effect

        // R5 wrap downward and upward
        pulse(4'b0010); row = row - 1'b1;
        do_store(row, 1'b0);
        check(row == 13'h1FFF, "R5 wrap below zero", 64'(row), 64'h1FFF);
        pulse(4'b0001); row = row + 1'b1;
        do_fetch(row, 1'b0);

        // R10 priority: up with store in the same cycle only moves the row
        oldw = wr_cnt;
        pulse(4'b0101); row = row + 1'b1;
        repeat (6) @(negedge clk);
        #1;
        check(wr_cnt == oldw, "R10 priority up over store", 64'(wr_cnt - oldw), 64'd0);
        do_store(row, 1'b0);

        spurious_en = 1;
        for (int i = 0; i < 200; i++) begin
            int op = int'($urandom % 4);
            bit extra = ($urandom % 4) == 0;
            case (op)
                0: begin pulse(4'b0001); row = row + 1'b1; end
                1: begin pulse(4'b0010); row = row - 1'b1; end
                2: do_store(row, extra);     // extra up pulse ignored (R10)
                default: do_fetch(row, extra); // extra down pulse ignored (R10)
            endcase
            if (extra && op >= 2) begin
                do_store(row, 1'b0);
            end
        end
        spurious_en = 0;

        // R11 reset in the middle of operation
        repeat (4) @(negedge clk);
        #1;
        rst = 1'b1;
        init_done = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(led_ready == 1'b0, "R11 status cleared", 64'(led_ready), 64'd0);
        check(led == 8'd0, "R11 display cleared", 64'(led), 64'd0);
        rst = 1'b0;
        oldw = wr_cnt;
        oldr = rd_cnt;
        repeat (10) @(negedge clk);
        #1;
        check(wr_cnt == oldw && rd_cnt == oldr, "R1 quiet after reset",
              64'(wr_cnt - oldw + rd_cnt - oldr), 64'd0);
        startup_and_check(1'b0);
        do_store(13'd0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule